// File: doc/BRIEF.md
# Console Cartridge Address Mapper

This block sits on the 24-bit address bus of a console CPU. The bus carries an 8-bit bank and a 16-bit offset. For each access the block decides which target it belongs to: work RAM, the hardware register area, cartridge ROM, battery-backed save RAM, or nothing. It drives exactly one of five select outputs for that target. It also forms the linear address that the selected memory needs. A static mode input picks between two ROM packing schemes:

- **Half-bank packing:** each bank contributes 32 KB of ROM in its upper half.
- **Full-bank packing:** whole 64 KB banks hold ROM, and the low banks show the upper half of each of those 64 KB chunks.

The upper half of the bank space (banks 80-FF) repeats the lower half. The exception is full-bank packing, which places ROM in the top banks.

A single speed bit lives in the register area. It selects the faster access timing for banks 80 and above. Banks below 80 always use slow timing. The ROM and save RAM address outputs are only as wide as their parameters allow. A smaller device therefore repeats through its window.

Top module: `cart_addr_map`

## Requirements
- R1: In banks 00-3F and 80-BF, offsets 0000-1FFF assert wram_cs with wram_addr equal to the offset. The same low RAM is therefore seen in every such bank, including address 00:1001 and 7E:1001.
- R2: Banks 7E and 7F form 128 KB of work RAM with wram_addr = {bank[0], offset}. With hirom_mode = 0, banks FE and FF repeat them.
- R3: In banks 00-3F and 80-BF, offsets 2000-5FFF assert io_cs. io_sub then encodes the sub-area: 0 for 2000-2FFF, 1 for 3000-3FFF, 2 for 4000-41FF, 3 for 4200-5FFF.
- R4: With hirom_mode = 0, offsets 8000-FFFF of banks 00-7D (and of their mirrors 80-FD) assert rom_cs. rom_addr is then {bank[6:0], offset[14:0]}.
- R5: With hirom_mode = 1, banks 40-7D and C0-FF assert rom_cs over the full offset range. Offsets 8000-FFFF of banks 00-3F and 80-BF also assert rom_cs. In all of these cases rom_addr = {bank[5:0], offset}.
- R6: With hirom_mode = 0, offsets 0000-7FFF of banks 70-77 and F0-F7 assert sram_cs with sram_addr = {bank[2:0], offset[14:0]}.
- R7: With hirom_mode = 1, offsets 6000-7FFF of banks 30-3F and B0-BF assert sram_cs with sram_addr = {bank[3:0], offset[12:0]}.
- R8: rom_addr and sram_addr carry only the low ROM_AW and SRAM_AW bits of the formulas in R4-R7 (defaults 21 and 15). Higher windows therefore repeat the device from its start.
- R9: Exactly one of wram_cs, io_cs, rom_cs, sram_cs and unmapped is high for every address. unmapped covers every address not claimed by R1-R7, for example 00:6000 in both modes and 40:1234 with hirom_mode = 0. Each address output is zero while its select is low.
- R10: After reset the speed bit is 0, so fast_cycle is 0 for every bank.
- R11: A cycle with cpu_wr high at offset 420D in banks 00-3F or 80-BF loads cpu_wdata_b0 into the speed bit. The new value is seen from the next cycle. A write at any other offset or bank, or a read at 420D, leaves the speed bit unchanged.
- R12: fast_cycle is high only when bank bit 7 is set and the speed bit is 1. Banks 00-7F always give fast_cycle = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hirom_mode | input | 1 | Static packing select: 0 half-bank, 1 full-bank |
| cpu_bank | input | 8 | Bank part of the address |
| cpu_ofs | input | 16 | Offset part of the address |
| cpu_wr | input | 1 | Write strobe for the current access |
| cpu_wdata_b0 | input | 1 | Bit 0 of the write data |
| wram_cs | output | 1 | Work RAM select |
| io_cs | output | 1 | Hardware register area select |
| rom_cs | output | 1 | Cartridge ROM select |
| sram_cs | output | 1 | Save RAM select |
| unmapped | output | 1 | Address claimed by no target |
| io_sub | output | 2 | Register sub-area code, valid with io_cs |
| wram_addr | output | 17 | Linear work RAM address |
| rom_addr | output | ROM_AW | Linear ROM address |
| sram_addr | output | SRAM_AW | Linear save RAM address |
| fast_cycle | output | 1 | Fast access timing for this cycle |

## Verification
The hardest case to reach from the ports is a write that must be ignored. The bench first sets the speed bit through a legal write at 420D. It then writes at that offset in an out-of-range bank, writes at the neighbouring offset 420C, and reads 420D. After each of these it probes an upper bank to show that fast_cycle stayed high. A final write to the mirror bank 80 clears the bit. The address folding of R8 is driven by picking banks whose formula overflows the default widths in both modes, so that these accesses must land back at the start of the device.

// File: rtl/cam_pkg.sv
package cam_pkg;

  localparam int WRAM_AW = 17;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_WRAM = 3'd1,
    RG_IO   = 3'd2,
    RG_ROM  = 3'd3,
    RG_SRAM = 3'd4
  } cam_region_e;

endpackage

// File: rtl/cam_region_decode.sv
module cam_region_decode
  import cam_pkg::*;
(
  input  logic [7:0]  bank,
  input  logic [15:0] ofs,
  input  logic        hirom,
  output cam_region_e region,
  output logic [1:0]  io_sub
);

  logic [6:0] lb;
  logic       upper;
  logic       low_bank;
  logic       wram_bank;
  logic       lo_sram_bank;
  logic       hi_sram_bank;

  assign lb           = bank[6:0];
  assign upper        = bank[7];
  assign low_bank     = ~lb[6];
  // 7E/7F hold work RAM; FE/FF follow them unless full-bank packing claims them
  assign wram_bank    = (lb[6:1] == 6'h3F) && !(upper && hirom);
  assign lo_sram_bank = (lb[6:3] == 4'b1110);
  assign hi_sram_bank = (lb[5:4] == 2'b11);

  always_comb begin
    region = RG_NONE;
    if (wram_bank) begin
      region = RG_WRAM;
    end else if (low_bank) begin
      if (ofs[15:13] == 3'b000)      region = RG_WRAM;
      else if (ofs[15])              region = RG_ROM;
      else if (ofs[15:13] == 3'b011) region = (hirom && hi_sram_bank) ? RG_SRAM : RG_NONE;
      else                           region = RG_IO;
    end else begin
      if (hirom)                     region = RG_ROM;
      else if (ofs[15])              region = RG_ROM;
      else if (lo_sram_bank)         region = RG_SRAM;
      else                           region = RG_NONE;
    end
  end

  always_comb begin
    if (ofs[15:12] == 4'h2)           io_sub = 2'd0;
    else if (ofs[15:12] == 4'h3)      io_sub = 2'd1;
    else if (ofs[15:9] == 7'b0100000) io_sub = 2'd2;
    else                              io_sub = 2'd3;
  end

endmodule

// File: rtl/cam_addr_form.sv
module cam_addr_form
  import cam_pkg::*;
#(
  parameter int ROM_AW  = 21,
  parameter int SRAM_AW = 15
) (
  input  logic [6:0]         bank7,
  input  logic [15:0]        ofs,
  input  logic               hirom,
  input  cam_region_e        region,
  output logic [WRAM_AW-1:0] wram_addr,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic [SRAM_AW-1:0] sram_addr
);

  localparam int ROM_FULL_W  = 22;
  localparam int SRAM_FULL_W = 18;

  logic [ROM_FULL_W-1:0]  rom_full;
  logic [SRAM_FULL_W-1:0] sram_full;
  logic [WRAM_AW-1:0]     wram_full;

  always_comb begin
    if (hirom) rom_full = {bank7[5:0], ofs};
    else       rom_full = {bank7, ofs[14:0]};
  end

  always_comb begin
    if (hirom) sram_full = {1'b0, bank7[3:0], ofs[12:0]};
    else       sram_full = {bank7[2:0], ofs[14:0]};
  end

  // only 7E/7F (or their mirrors) reach work RAM with bank bit 6 set
  always_comb begin
    if (bank7[6]) wram_full = {bank7[0], ofs};
    else          wram_full = {4'b0000, ofs[12:0]};
  end

  generate
    if (ROM_AW >= ROM_FULL_W) begin : g_rom_wide
      assign rom_addr = (region == RG_ROM) ? ROM_AW'(rom_full) : '0;
    end else begin : g_rom_fold
      logic [ROM_FULL_W-1:0] rom_mask;
      assign rom_mask = (ROM_FULL_W'(1) << ROM_AW) - ROM_FULL_W'(1);
      logic [ROM_FULL_W-1:0] rom_kept;
      assign rom_kept = rom_full & rom_mask;
      assign rom_addr = (region == RG_ROM) ? rom_kept[ROM_AW-1:0] : '0;
    end

    if (SRAM_AW >= SRAM_FULL_W) begin : g_sram_wide
      assign sram_addr = (region == RG_SRAM) ? SRAM_AW'(sram_full) : '0;
    end else begin : g_sram_fold
      logic [SRAM_FULL_W-1:0] sram_mask;
      assign sram_mask = (SRAM_FULL_W'(1) << SRAM_AW) - SRAM_FULL_W'(1);
      logic [SRAM_FULL_W-1:0] sram_kept;
      assign sram_kept = sram_full & sram_mask;
      assign sram_addr = (region == RG_SRAM) ? sram_kept[SRAM_AW-1:0] : '0;
    end
  endgenerate

  assign wram_addr = (region == RG_WRAM) ? wram_full : '0;

endmodule

// File: rtl/cam_speed_ctl.sv
module cam_speed_ctl #(
  parameter logic [15:0] SPEED_OFS = 16'h420D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        bank6,
  input  logic [15:0] ofs,
  input  logic        wdata_b0,
  output logic        spd_q
);

  logic load_en;
  logic spd_d;

  // register area exists only where bank bit 6 is clear (00-3F, 80-BF)
  assign load_en = wr && !bank6 && (ofs == SPEED_OFS);

  always_comb begin
    spd_d = spd_q;
    if (load_en) spd_d = wdata_b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spd_q <= 1'b0;
    else if (load_en) spd_q <= spd_d;
  end

endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
  import cam_pkg::*;
#(
  parameter int          ROM_AW    = 21,
  parameter int          SRAM_AW   = 15,
  parameter logic [15:0] SPEED_OFS = 16'h420D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hirom_mode,
  input  logic [7:0]         cpu_bank,
  input  logic [15:0]        cpu_ofs,
  input  logic               cpu_wr,
  input  logic               cpu_wdata_b0,
  output logic               wram_cs,
  output logic               io_cs,
  output logic               rom_cs,
  output logic               sram_cs,
  output logic               unmapped,
  output logic [1:0]         io_sub,
  output logic [WRAM_AW-1:0] wram_addr,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               fast_cycle
);

  cam_region_e region;
  logic        spd_q;

  cam_region_decode u_dec (
    .bank   (cpu_bank),
    .ofs    (cpu_ofs),
    .hirom  (hirom_mode),
    .region (region),
    .io_sub (io_sub)
  );

  cam_addr_form #(
    .ROM_AW  (ROM_AW),
    .SRAM_AW (SRAM_AW)
  ) u_addr (
    .bank7     (cpu_bank[6:0]),
    .ofs       (cpu_ofs),
    .hirom     (hirom_mode),
    .region    (region),
    .wram_addr (wram_addr),
    .rom_addr  (rom_addr),
    .sram_addr (sram_addr)
  );

  cam_speed_ctl #(
    .SPEED_OFS (SPEED_OFS)
  ) u_spd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cpu_wr),
    .bank6    (cpu_bank[6]),
    .ofs      (cpu_ofs),
    .wdata_b0 (cpu_wdata_b0),
    .spd_q    (spd_q)
  );

  assign wram_cs    = (region == RG_WRAM);
  assign io_cs      = (region == RG_IO);
  assign rom_cs     = (region == RG_ROM);
  assign sram_cs    = (region == RG_SRAM);
  assign unmapped   = (region == RG_NONE);
  assign fast_cycle = cpu_bank[7] && spd_q;

endmodule

// File: rtl/cart_addr_map_chk.sv
module cart_addr_map_chk #(
  parameter int ROM_AW  = 21,
  parameter int SRAM_AW = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         cpu_bank,
  input logic [15:0]        cpu_ofs,
  input logic               cpu_wr,
  input logic               cpu_wdata_b0,
  input logic               wram_cs,
  input logic               io_cs,
  input logic               rom_cs,
  input logic               sram_cs,
  input logic               unmapped,
  input logic [16:0]        wram_addr,
  input logic [ROM_AW-1:0]  rom_addr,
  input logic [SRAM_AW-1:0] sram_addr,
  input logic               fast_cycle,
  input logic               spd_q
);

  logic spd_hit;
  assign spd_hit = cpu_wr && !cpu_bank[6] && (cpu_ofs == 16'h420D);

  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wram_cs, io_cs, rom_cs, sram_cs, unmapped}) == 1);

  a_r9_rom_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs |-> (rom_addr == '0));

  a_r9_sram_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs |-> (sram_addr == '0));

  a_r1_lowram_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_bank[6] && cpu_ofs[15:13] == 3'b000) |-> (wram_cs && wram_addr == {4'b0000, cpu_ofs[12:0]}));

  a_r3_reg_area: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_bank[6] && (cpu_ofs[15:13] == 3'b001 || cpu_ofs[15:13] == 3'b010)) |-> io_cs);

  a_r11_speed_load: assert property (@(posedge clk) disable iff (!rst_n)
    spd_hit |=> (spd_q == $past(cpu_wdata_b0)));

  a_r11_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !spd_hit |=> $stable(spd_q));

  a_r12_low_half_slow: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_bank[7] |-> !fast_cycle);

endmodule

bind cart_addr_map cart_addr_map_chk #(
  .ROM_AW  (ROM_AW),
  .SRAM_AW (SRAM_AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_bank     (cpu_bank),
  .cpu_ofs      (cpu_ofs),
  .cpu_wr       (cpu_wr),
  .cpu_wdata_b0 (cpu_wdata_b0),
  .wram_cs      (wram_cs),
  .io_cs        (io_cs),
  .rom_cs       (rom_cs),
  .sram_cs      (sram_cs),
  .unmapped     (unmapped),
  .wram_addr    (wram_addr),
  .rom_addr     (rom_addr),
  .sram_addr    (sram_addr),
  .fast_cycle   (fast_cycle),
  .spd_q        (spd_q)
);

// File: tb/cart_addr_map_test.sv
module cart_addr_map_test;

  localparam int ROM_AW  = 21;
  localparam int SRAM_AW = 15;

  localparam logic [4:0] S_WR = 5'b10000;
  localparam logic [4:0] S_IO = 5'b01000;
  localparam logic [4:0] S_RM = 5'b00100;
  localparam logic [4:0] S_SR = 5'b00010;
  localparam logic [4:0] S_UN = 5'b00001;

  typedef struct {
    logic [7:0]  bank;
    logic [15:0] ofs;
    logic [4:0]  sel;
    logic [31:0] addr;
    logic [1:0]  sub;
    logic        fast;
    string       tag;
  } item_t;

  logic               clk;
  logic               rst_n;
  logic               hirom_mode;
  logic [7:0]         cpu_bank;
  logic [15:0]        cpu_ofs;
  logic               cpu_wr;
  logic               cpu_wdata_b0;
  logic               wram_cs, io_cs, rom_cs, sram_cs, unmapped;
  logic [1:0]         io_sub;
  logic [16:0]        wram_addr;
  logic [ROM_AW-1:0]  rom_addr;
  logic [SRAM_AW-1:0] sram_addr;
  logic               fast_cycle;

  item_t exp_q[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;

  cart_addr_map #(
    .ROM_AW  (ROM_AW),
    .SRAM_AW (SRAM_AW)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hirom_mode   (hirom_mode),
    .cpu_bank     (cpu_bank),
    .cpu_ofs      (cpu_ofs),
    .cpu_wr       (cpu_wr),
    .cpu_wdata_b0 (cpu_wdata_b0),
    .wram_cs      (wram_cs),
    .io_cs        (io_cs),
    .rom_cs       (rom_cs),
    .sram_cs      (sram_cs),
    .unmapped     (unmapped),
    .io_sub       (io_sub),
    .wram_addr    (wram_addr),
    .rom_addr     (rom_addr),
    .sram_addr    (sram_addr),
    .fast_cycle   (fast_cycle)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // driver: one access per cycle, expected result pushed with it
  task automatic access(input logic hi, input logic [7:0] b, input logic [15:0] o,
                        input logic wr, input logic d, input logic [4:0] sel,
                        input logic [31:0] addr, input logic [1:0] sub,
                        input logic fast, input string tag);
    item_t it;
    @(negedge clk);
    hirom_mode   = hi;
    cpu_bank     = b;
    cpu_ofs      = o;
    cpu_wr       = wr;
    cpu_wdata_b0 = d;
    it.bank = b; it.ofs = o; it.sel = sel; it.addr = addr;
    it.sub = sub; it.fast = fast; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: samples mid-way through the low clock phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        item_t it;
        logic [4:0]  act_sel;
        logic [31:0] act_addr;
        bit          ok;
        it       = exp_q.pop_front();
        act_sel  = {wram_cs, io_cs, rom_cs, sram_cs, unmapped};
        act_addr = {15'b0, wram_addr} | 32'(rom_addr) | 32'(sram_addr);
        ok = (act_sel == it.sel) && (act_addr == it.addr) && (fast_cycle == it.fast);
        if (it.sel == S_IO) ok = ok && (io_sub == it.sub);
        total++;
        if (!ok) begin
          bad++;
          $display("FAIL %s at %02h:%04h sel=%b/%b addr=%h/%h sub=%0d/%0d fast=%0b/%0b (actual/expected)",
                   it.tag, it.bank, it.ofs, act_sel, it.sel, act_addr, it.addr,
                   io_sub, it.sub, fast_cycle, it.fast);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hirom_mode = 1'b0; cpu_bank = 8'h00; cpu_ofs = 16'h0000;
    cpu_wr = 1'b0; cpu_wdata_b0 = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state: upper bank slow
    access(0, 8'h80, 16'h8000, 0, 0, S_RM, 32'h0, 0, 0, "R10 reset slow");

    // R1 low RAM alias
    access(0, 8'h00, 16'h1001, 0, 0, S_WR, 32'h01001, 0, 0, "R1 00:1001");
    access(0, 8'h80, 16'h0005, 0, 0, S_WR, 32'h00005, 0, 0, "R1 mirror 80");
    access(1, 8'hBF, 16'h1FFF, 0, 0, S_WR, 32'h01FFF, 0, 0, "R1 BF top");
    // R2 work RAM banks
    access(0, 8'h7E, 16'h1001, 0, 0, S_WR, 32'h01001, 0, 0, "R2 7E:1001");
    access(0, 8'h7F, 16'h1234, 0, 0, S_WR, 32'h11234, 0, 0, "R2 7F");
    access(0, 8'hFF, 16'h0010, 0, 0, S_WR, 32'h10010, 0, 0, "R2 FF mirror");
    access(0, 8'hFE, 16'h1234, 0, 0, S_WR, 32'h01234, 0, 0, "R2 FE mirror");
    access(1, 8'h7F, 16'h8000, 0, 0, S_WR, 32'h18000, 0, 0, "R2 full-bank 7F");

    // R3 register sub-areas
    access(0, 8'h00, 16'h2100, 0, 0, S_IO, 32'h0, 0, 0, "R3 sub0");
    access(0, 8'h00, 16'h3010, 0, 0, S_IO, 32'h0, 1, 0, "R3 sub1");
    access(0, 8'h00, 16'h4016, 0, 0, S_IO, 32'h0, 2, 0, "R3 sub2");
    access(1, 8'h00, 16'h41FF, 0, 0, S_IO, 32'h0, 2, 0, "R3 sub2 edge");
    access(0, 8'h00, 16'h4200, 0, 0, S_IO, 32'h0, 3, 0, "R3 sub3");
    access(0, 8'h80, 16'h5FFF, 0, 0, S_IO, 32'h0, 3, 0, "R3 sub3 mirror");

    // R4 half-bank ROM
    access(0, 8'h00, 16'h8000, 0, 0, S_RM, 32'h000000, 0, 0, "R4 first");
    access(0, 8'h01, 16'h8000, 0, 0, S_RM, 32'h008000, 0, 0, "R4 bank1");
    access(0, 8'h3F, 16'hFFFF, 0, 0, S_RM, 32'h1FFFFF, 0, 0, "R4 3F top");
    // R8 folding of ROM
    access(0, 8'h40, 16'h8000, 0, 0, S_RM, 32'h000000, 0, 0, "R8 rom fold 40");
    access(0, 8'hC1, 16'h9234, 0, 0, S_RM, 32'h009234, 0, 0, "R8 rom fold C1");
    access(0, 8'h70, 16'h8000, 0, 0, S_RM, 32'h180000, 0, 0, "R4 70 upper");

    // R6 half-bank save RAM
    access(0, 8'h70, 16'h0000, 0, 0, S_SR, 32'h0000, 0, 0, "R6 70 start");
    access(0, 8'h70, 16'h7FFF, 0, 0, S_SR, 32'h7FFF, 0, 0, "R6 70 end");
    access(0, 8'h71, 16'h0123, 0, 0, S_SR, 32'h0123, 0, 0, "R8 sram fold 71");
    access(0, 8'hF2, 16'h0040, 0, 0, S_SR, 32'h0040, 0, 0, "R6 F2 mirror");

    // R9 unmapped, half-bank
    access(0, 8'h00, 16'h6000, 0, 0, S_UN, 32'h0, 0, 0, "R9 lo 00:6000");
    access(0, 8'h40, 16'h1234, 0, 0, S_UN, 32'h0, 0, 0, "R9 lo 40:1234");
    access(0, 8'h78, 16'h0000, 0, 0, S_UN, 32'h0, 0, 0, "R9 lo 78");
    access(0, 8'h7D, 16'h7FFF, 0, 0, S_UN, 32'h0, 0, 0, "R9 lo 7D");

    // R5 full-bank ROM
    access(1, 8'h40, 16'h0000, 0, 0, S_RM, 32'h000000, 0, 0, "R5 40 start");
    access(1, 8'h41, 16'h1234, 0, 0, S_RM, 32'h011234, 0, 0, "R5 41");
    access(1, 8'h7D, 16'hFFFF, 0, 0, S_RM, 32'h1DFFFF, 0, 0, "R8 hi 7D fold");
    access(1, 8'hC0, 16'h0000, 0, 0, S_RM, 32'h000000, 0, 0, "R5 C0");
    access(1, 8'hFE, 16'h0010, 0, 0, S_RM, 32'h1E0010, 0, 0, "R5 FE not wram");
    access(1, 8'hFF, 16'hFFFF, 0, 0, S_RM, 32'h1FFFFF, 0, 0, "R5 FF top");
    access(1, 8'h00, 16'h8000, 0, 0, S_RM, 32'h008000, 0, 0, "R5 00 upper half");
    access(1, 8'h05, 16'h9000, 0, 0, S_RM, 32'h059000, 0, 0, "R5 05 upper half");
    access(1, 8'h70, 16'h0000, 0, 0, S_RM, 32'h100000, 0, 0, "R5 70 is rom");
    access(1, 8'h7E, 16'h0000, 0, 0, S_WR, 32'h00000, 0, 0, "R2 full-bank 7E");

    // R7 full-bank save RAM
    access(1, 8'h30, 16'h6000, 0, 0, S_SR, 32'h0000, 0, 0, "R7 30 start");
    access(1, 8'h31, 16'h6001, 0, 0, S_SR, 32'h2001, 0, 0, "R7 31");
    access(1, 8'h3F, 16'h7FFF, 0, 0, S_SR, 32'h7FFF, 0, 0, "R8 hi 3F fold");
    access(1, 8'hB2, 16'h6010, 0, 0, S_SR, 32'h4010, 0, 0, "R7 B2 mirror");
    access(1, 8'h34, 16'h6000, 0, 0, S_SR, 32'h0000, 0, 0, "R8 hi 34 fold");
    access(1, 8'h2F, 16'h6000, 0, 0, S_UN, 32'h0, 0, 0, "R9 hi 2F:6000");
    access(1, 8'h00, 16'h7FFF, 0, 0, S_UN, 32'h0, 0, 0, "R9 hi 00:7FFF");

    // R11/R12 speed bit
    access(0, 8'h00, 16'h420D, 1, 1, S_IO, 32'h0, 3, 0, "R11 set write");
    access(0, 8'h80, 16'h8000, 0, 0, S_RM, 32'h0, 0, 1, "R12 upper fast");
    access(0, 8'h00, 16'h8000, 0, 0, S_RM, 32'h0, 0, 0, "R12 lower slow");
    access(0, 8'h7F, 16'h0000, 0, 0, S_WR, 32'h10000, 0, 0, "R12 7F slow");
    access(0, 8'h40, 16'h420D, 1, 0, S_UN, 32'h0, 0, 0, "R11 bank 40 write");
    access(0, 8'h80, 16'h8000, 0, 0, S_RM, 32'h0, 0, 1, "R11 bank 40 ignored");
    access(0, 8'h00, 16'h420C, 1, 0, S_IO, 32'h0, 3, 0, "R11 420C write");
    access(0, 8'hC0, 16'h8000, 0, 0, S_RM, 32'h0, 0, 1, "R11 420C ignored");
    access(0, 8'h00, 16'h420D, 0, 0, S_IO, 32'h0, 3, 0, "R11 read 420D");
    access(0, 8'h80, 16'h8000, 0, 0, S_RM, 32'h0, 0, 1, "R11 read ignored");
    access(0, 8'h80, 16'h420D, 1, 0, S_IO, 32'h0, 3, 1, "R11 clear via 80");
    access(0, 8'h80, 16'h8000, 0, 0, S_RM, 32'h0, 0, 0, "R11 cleared");

    @(negedge clk);
    cpu_wr = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule